// File: doc/BRIEF.md
# GF(2) Control Word Solver for Scan Chain Gating

This block takes a connection matrix that ties control bits to scan chain gating signals, plus a mask of chains a test cube needs enabled. It searches for a control word under which every required chain's gating signal, the XOR of its connected control bits, equals 1. Only the required chains contribute equations, each with target value 1. The system is solved by sequential Gauss-Jordan elimination over GF(2), with one pivot column handled per clock cycle on a small row buffer held inside the block.

Control bits that no pivot fixes are filled from an internal 16-bit LFSR, so repeated solves of an underdetermined system give varied words. An inconsistent system is reported as an encoding failure. After a successful solve, the block decodes the XOR network again with the result and raises `verified` only when every required chain decodes to 1. The caller pulses `start` with the matrix and mask and waits for the one-cycle `done` pulse. The results stay valid until the next accepted start.

Top module: `gf2_ctrl_solver`

## Requirements
- R1: Chain i's gating value is the XOR of the control bits j for which `conn_matrix[i*N_CTRL + j]` is 1. Control bit j is `ctrl_word[j]`.
- R2: On `done` with `fail` low, every chain i with `req_mask[i]` = 1 has gating value 1 under `ctrl_word`.
- R3: Chains with `req_mask[i]` = 0 put no constraint on the result. An all-zero row on an unrequired chain does not cause failure.
- R4: `fail` is 1 at `done` exactly when no control word satisfies all required chains. On failure `ctrl_word` is 0 and `verified` is 0.
- R5: When every required row has an odd number of ones, `fail` is never raised.
- R6: Control bits left free by the elimination take values from a 16-bit LFSR with a nonzero seed. The LFSR advances once per free bit, so repeated solves with an empty mask do not all return the same word.
- R7: On success, `verified` is 1. It comes from a separate decode of the result against the stored matrix and mask.
- R8: `done` is a one-cycle pulse. It follows the clock edge that accepts `start` by 2*N_CTRL+3 edges on success and by N_CTRL+1 edges on failure.
- R9: A `start` that arrives while a solve is in progress is ignored. The running solve finishes with its own matrix and mask.
- R10: After reset, `done`, `fail` and `verified` are 0 and `ctrl_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a solve. Accepted only when idle |
| conn_matrix | input | N_CHAIN*N_CTRL | Row i in bits [i*N_CTRL +: N_CTRL]. Bit j connects control bit j to chain i |
| req_mask | input | N_CHAIN | Chains that must be enabled |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No consistent control word exists |
| verified | output | 1 | Result decodes every required chain to 1 |
| ctrl_word | output | N_CTRL | Solved control word |

## Verification
The solver's latency is fixed by its outcome. `done` rises 2*N_CTRL+3 edges after the accepting edge on success and N_CTRL+1 edges after it on failure. The bench counts falling edges from the accepting edge and compares the count at the `done` pulse against whichever figure the bench's own brute-force search over all control words predicts. It reads `fail`, `verified` and `ctrl_word` at that same falling edge, since they hold from there until the next start. It then samples one falling edge later to confirm that `done` has dropped.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ELIM,
        S_CHECK,
        S_FILL,
        S_SOLVE,
        S_VERIFY,
        S_DONE
    } gfs_state_e;

    localparam int RNG_W = 16;
endpackage

// File: rtl/gfs_lfsr.sv
module gfs_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic bit_o
);
    import gfs_pkg::*;

    logic [RNG_W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (adv) begin
            state_d = {state_q[RNG_W-2:0],
                       state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign bit_o = state_q[15];

    AST_RNG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R6
endmodule

// File: rtl/gfs_pivot_find.sv
module gfs_pivot_find #(
    parameter int N  = 8,
    parameter int PW = 4
) (
    input  logic [N-1:0]  col_bits,
    input  logic [PW-1:0] start_row,
    output logic          found,
    output logic [PW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int r = 0; r < N; r++) begin
            if (!found && (PW'(r) >= start_row) && col_bits[r]) begin
                found = 1'b1;
                idx   = PW'(r);
            end
        end
    end
endmodule

// File: rtl/gfs_xor_decode.sv
module gfs_xor_decode #(
    parameter int N = 8,
    parameter int C = 6
) (
    input  logic [N*C-1:0] matrix,
    input  logic [C-1:0]   word,
    output logic [N-1:0]   gating
);
    for (genvar i = 0; i < N; i++) begin : g_row
        assign gating[i] = ^(matrix[i*C +: C] & word);
    end
endmodule

// File: rtl/gf2_ctrl_solver.sv
module gf2_ctrl_solver #(
    parameter int          N_CHAIN   = 8,
    parameter int          N_CTRL    = 6,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [N_CHAIN*N_CTRL-1:0] conn_matrix,
    input  logic [N_CHAIN-1:0]        req_mask,
    output logic                      done,
    output logic                      fail,
    output logic                      verified,
    output logic [N_CTRL-1:0]         ctrl_word
);
    import gfs_pkg::*;

    localparam int N  = N_CHAIN;
    localparam int C  = N_CTRL;
    localparam int CW = $clog2(C + 1);
    localparam int PW = $clog2(N + 1);

    typedef logic [C:0] row_t;

    typedef struct {
        gfs_state_e      st;
        row_t            rows [N];
        logic [CW-1:0]   piv  [N];
        logic [CW-1:0]   col;
        logic [PW-1:0]   prow;
        logic [C-1:0]    free;
        logic [C-1:0]    word;
        logic [N-1:0]    mask;
        logic [N*C-1:0]  mat;
        logic            odd;
        logic            fail;
        logic            verified;
    } solver_t;

    solver_t q, d;

    logic [N-1:0]  col_bits;
    logic          piv_found;
    logic [PW-1:0] piv_idx;
    logic          rng_adv;
    logic          rng_bit;
    logic [N-1:0]  gating;
    row_t          col_sel;

    assign col_sel = row_t'(1) << q.col;

    always_comb begin
        for (int r = 0; r < N; r++) col_bits[r] = |(q.rows[r] & col_sel);
    end

    gfs_pivot_find #(.N(N), .PW(PW)) u_piv (
        .col_bits  (col_bits),
        .start_row (q.prow),
        .found     (piv_found),
        .idx       (piv_idx)
    );

    gfs_lfsr #(.SEED(LFSR_SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (rng_adv),
        .bit_o (rng_bit)
    );

    gfs_xor_decode #(.N(N), .C(C)) u_dec (
        .matrix (q.mat),
        .word   (q.word),
        .gating (gating)
    );

    always_comb begin
        row_t       pivot_row;
        row_t       base_row;
        row_t       tmp [N];
        logic [C-1:0] bit_sel;
        logic       bad;
        logic       val;

        d         = q;
        rng_adv   = 1'b0;
        pivot_row = '0;
        base_row  = '0;
        bad       = 1'b0;
        val       = 1'b0;
        bit_sel   = col_sel[C-1:0];
        for (int r = 0; r < N; r++) tmp[r] = q.rows[r];

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.odd = 1'b1;
                    for (int r = 0; r < N; r++) begin
                        d.rows[r] = req_mask[r] ? {1'b1, conn_matrix[r*C +: C]} : '0;
                        d.piv[r]  = '0;
                        if (req_mask[r] && !(^conn_matrix[r*C +: C])) d.odd = 1'b0;
                    end
                    d.mask     = req_mask;
                    d.mat      = conn_matrix;
                    d.col      = '0;
                    d.prow     = '0;
                    d.free     = '0;
                    d.word     = '0;
                    d.fail     = 1'b0;
                    d.verified = 1'b0;
                    d.st       = S_ELIM;
                end
            end
            S_ELIM: begin
                if (piv_found) begin
                    for (int r = 0; r < N; r++) begin
                        if (r == int'(piv_idx))  pivot_row = q.rows[r];
                        if (r == int'(q.prow))   base_row  = q.rows[r];
                    end
                    for (int r = 0; r < N; r++) begin
                        if (r == int'(q.prow))        tmp[r] = pivot_row;
                        else if (r == int'(piv_idx))  tmp[r] = base_row;
                    end
                    for (int r = 0; r < N; r++) begin
                        if ((r != int'(q.prow)) && |(tmp[r] & col_sel))
                            tmp[r] = tmp[r] ^ pivot_row;
                        if (r == int'(q.prow)) d.piv[r] = q.col;
                    end
                    for (int r = 0; r < N; r++) d.rows[r] = tmp[r];
                    d.prow = q.prow + 1'b1;
                end else begin
                    d.free = q.free | bit_sel;
                end
                d.col = q.col + 1'b1;
                if (int'(q.col) == C - 1) d.st = S_CHECK;
            end
            S_CHECK: begin
                for (int r = 0; r < N; r++)
                    if ((q.rows[r][C-1:0] == '0) && q.rows[r][C]) bad = 1'b1;
                d.col = '0;
                if (bad) begin
                    d.fail     = 1'b1;
                    d.word     = '0;
                    d.verified = 1'b0;
                    d.st       = S_DONE;
                end else begin
                    d.st = S_FILL;
                end
            end
            S_FILL: begin
                if (|(q.free & bit_sel)) begin
                    rng_adv = 1'b1;
                    d.word  = rng_bit ? (q.word | bit_sel) : (q.word & ~bit_sel);
                end
                d.col = q.col + 1'b1;
                if (int'(q.col) == C - 1) d.st = S_SOLVE;
            end
            S_SOLVE: begin
                for (int r = 0; r < N; r++) begin
                    if (r < int'(q.prow)) begin
                        val     = q.rows[r][C] ^ (^(q.rows[r][C-1:0] & q.free & q.word));
                        bit_sel = C'(1) << q.piv[r];
                        d.word  = val ? (d.word | bit_sel) : (d.word & ~bit_sel);
                    end
                end
                d.st = S_VERIFY;
            end
            S_VERIFY: begin
                d.verified = &(gating | ~q.mask);
                d.st       = S_DONE;
            end
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st <= S_IDLE;
            for (int r = 0; r < N; r++) begin
                q.rows[r] <= '0;
                q.piv[r]  <= '0;
            end
            q.col      <= '0;
            q.prow     <= '0;
            q.free     <= '0;
            q.word     <= '0;
            q.mask     <= '0;
            q.mat      <= '0;
            q.odd      <= 1'b0;
            q.fail     <= 1'b0;
            q.verified <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done      = (q.st == S_DONE);
    assign fail      = q.fail;
    assign verified  = q.verified;
    assign ctrl_word = q.word;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_FAIL_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (ctrl_word == '0 && !verified)); // R4
    AST_SUCCESS_VERIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> verified); // R7
    AST_ODD_NEVER_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.odd) |-> !fail); // R5
    AST_BUSY_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE && q.st != S_DONE && $past(q.st) != S_IDLE) |-> $stable(q.mask)); // R9
endmodule

// File: tb/sim_gf2_ctrl_solver.sv
module sim_gf2_ctrl_solver;
    localparam int  N      = 8;
    localparam int  C      = 6;
    localparam time CLK_T  = 10ns;
    localparam int  LAT_OK = 2*C + 3;
    localparam int  LAT_NG = C + 1;
    localparam int  NV     = 8;

    localparam logic [N*C-1:0] V_MAT [NV] = '{
        {6'b000010,6'b000001,6'b100000,6'b010000,6'b001000,6'b000100,6'b000010,6'b000001},
        {6'b101010,6'b101010,6'b101010,6'b101010,6'b101010,6'b000010,6'b000001,6'b000011},
        {6'b111111,6'b111111,6'b111111,6'b111111,6'b000000,6'b000011,6'b001100,6'b110000},
        {6'b111111,6'b111111,6'b111111,6'b111111,6'b000000,6'b000011,6'b001100,6'b110000},
        {6'b001011,6'b111110,6'b000001,6'b100000,6'b101010,6'b010101,6'b111000,6'b000111},
        {6'b001011,6'b111110,6'b000001,6'b100000,6'b101010,6'b010101,6'b111000,6'b000111},
        {6'b110011,6'b011110,6'b100101,6'b001111,6'b111100,6'b010010,6'b101001,6'b000110},
        {6'b010101,6'b010101,6'b010101,6'b010101,6'b010101,6'b101000,6'b011000,6'b110000}
    };
    localparam logic [N-1:0] V_MSK [NV] = '{
        8'hFF, 8'h07, 8'h0F, 8'h07, 8'hFF, 8'h00, 8'h5A, 8'h07
    };
    localparam string V_REQ [NV] = '{
        "R2", "R4", "R4", "R3", "R5", "R3", "R2", "R4"
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N*C-1:0] conn = '0;
    logic [N-1:0]   mask = '0;
    logic           done, fail, verified;
    logic [C-1:0]   word;

    int checks = 0;
    int errors = 0;
    int lat;

    always #(CLK_T/2) clk = ~clk;

    gf2_ctrl_solver #(.N_CHAIN(N), .N_CTRL(C)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .conn_matrix(conn),
        .req_mask(mask), .done(done), .fail(fail), .verified(verified),
        .ctrl_word(word)
    );

    function automatic bit covers(input logic [N*C-1:0] m, input logic [N-1:0] k,
                                  input logic [C-1:0] w);
        for (int i = 0; i < N; i++)
            if (k[i] && !(^(m[i*C +: C] & w))) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit solvable(input logic [N*C-1:0] m, input logic [N-1:0] k);
        for (int w = 0; w < (1 << C); w++)
            if (covers(m, k, C'(w))) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [N*C-1:0] m, input logic [N-1:0] k, input bit poke);
        @(negedge clk);
        conn = m; mask = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            if (poke && lat == 3) begin
                start = 1'b1; conn = ~m; mask = ~k;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        if (lat >= 100) chk(1'b0, "R8", "done never came", lat, 0);
    endtask

    task automatic judge(input logic [N*C-1:0] m, input logic [N-1:0] k, input string req);
        bit exp_fail;
        exp_fail = !solvable(m, k);
        chk(lat == (exp_fail ? LAT_NG : LAT_OK), "R8", "latency", lat,
            exp_fail ? LAT_NG : LAT_OK);
        chk(fail == exp_fail, req, "fail flag", fail, exp_fail);
        if (exp_fail) begin
            chk(word == '0, "R4", "word on failure", word, 0);
            chk(!verified, "R4", "verified on failure", verified, 0);
        end else begin
            chk(covers(m, k, word), req, "R2/R1 required chains decode to 1", word, k);
            chk(verified, "R7", "verified", verified, 1);
        end
        @(negedge clk);
        chk(!done, "R8", "done width", done, 0);
    endtask

    initial begin
        #(CLK_T * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [C-1:0] seen [4];
        bit           all_same;

        repeat (3) @(negedge clk);
        chk(!done && !fail && !verified && word == '0, "R10", "reset outputs",
            {done, fail, verified, word}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && word == '0, "R10", "idle after reset", {done, word}, 0);

        for (int v = 0; v < NV; v++) begin
            run(V_MAT[v], V_MSK[v], 1'b0);
            judge(V_MAT[v], V_MSK[v], V_REQ[v]);
        end

        // R5: all-odd rows, expected never to fail
        run(V_MAT[4], 8'hFF, 1'b0);
        chk(!fail, "R5", "odd rows solvable", fail, 0);

        // R9: a second start during the solve must be ignored
        run(V_MAT[1], V_MSK[1], 1'b1);
        judge(V_MAT[1], V_MSK[1], "R9");
        run(V_MAT[6], V_MSK[6], 1'b1);
        judge(V_MAT[6], V_MSK[6], "R9");

        // R6: empty mask leaves every bit free, filled from the LFSR
        for (int i = 0; i < 4; i++) begin
            run(V_MAT[0], '0, 1'b0);
            seen[i] = word;
        end
        all_same = (seen[0] == seen[1]) && (seen[1] == seen[2]) && (seen[2] == seen[3]);
        chk(!all_same, "R6", "random fill varies", seen[0], ~seen[0]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule